// File: doc/BRIEF.md
# Collision and Heartbeat Signal Generator

This block drives the collision indication that an Ethernet PHY presents to the MAC on its media-independent interface. The inputs are a transmit-active level and a receive-active level. Configuration levels give the line speed (10 or 100 Mb/s), the duplex setting, a heartbeat enable, and whether the MAC attachment is MII or reduced MII (RMII).

In half-duplex operation, the output flags any cycle in which transmit and receive are both active. At 10 Mb/s half-duplex with heartbeat enabled, the block also emits a signal-quality-error test pulse after each transmission ends. That pulse lasts one microsecond by default and is counted in cycles of the block clock.

Full-duplex operation holds the output low. The RMII attachment also holds it low, because a MAC on that interface derives collisions on its own side.

Top module: `col_hb_gen`

## Requirements
- R1: In half-duplex MII operation, when `tx_act_i` and `rx_act_i` are both high at a clock edge, `col_o` is high after the second rising edge from then, at either speed. It drops two edges after the overlap ends, unless a heartbeat pulse is running.
- R2: When `full_dup_i` is high at an edge, `col_o` is low after that edge, at either speed.
- R3: In 10 Mb/s half-duplex MII operation (`speed100_i`=0) with `hb_en_i`=1, a high-to-low change of `tx_act_i` sampled at edge E produces a `col_o` high for exactly `PULSE_CYC` cycles. The pulse starts after edge E+2.
- R4: In 10 Mb/s full-duplex operation, no heartbeat pulse follows the end of a transmission.
- R5: When `rmii_i` is high at an edge, `col_o` is low after that edge.
- R6: With `speed100_i`=1, no heartbeat pulse is produced, even when `hb_en_i` is 1.
- R7: With `hb_en_i`=0, no heartbeat pulse is produced.
- R8: If `tx_act_i` rises while a heartbeat pulse is running, the pulse ends after the second edge from the rise. While `tx_act_i` is high without receive activity, `col_o` is low one edge later.
- R9: `col_o` is a register output and is low while `rst_ni` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, `CLK_PER_US` cycles per microsecond |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_act_i | input | 1 | Transmit activity level |
| rx_act_i | input | 1 | Receive activity level |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_en_i | input | 1 | 1 = heartbeat test pulse enabled |
| rmii_i | input | 1 | 1 = reduced MII attachment, 0 = MII |
| col_o | output | 1 | Registered collision / heartbeat output |

## Verification
A true collision and a heartbeat pulse can drive `col_o` in the same cycle. Receive activity can start while the post-transmit pulse is counting, and a new transmission can begin on top of that receive activity. The bench raises `rx_act_i` partway through a pulse and then raises `tx_act_i`. It requires the output to stay high without a glitch through the handover from pulse to true collision. It also checks that the pulse timer is cleared, so the output drops exactly two edges after the overlap ends rather than finishing the old pulse.

// File: rtl/col_hb_pkg.sv
package col_hb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,  // output forced low
    MODE_COL_ONLY = 2'd1,  // overlap detection only
    MODE_COL_HB   = 2'd2   // overlap plus post-transmit test pulse
  } col_mode_e;
endpackage

// File: rtl/col_hb_mode.sv
module col_hb_mode
  import col_hb_pkg::*;
(
  input  logic      speed100_i,
  input  logic      full_dup_i,
  input  logic      hb_en_i,
  input  logic      rmii_i,
  output col_mode_e mode_o
);
  always_comb begin
    if (rmii_i || full_dup_i)       mode_o = MODE_OFF;
    else if (!speed100_i && hb_en_i) mode_o = MODE_COL_HB;
    else                             mode_o = MODE_COL_ONLY;
  end
endmodule

// File: rtl/col_hb_sync.sv
module col_hb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic rx_act_i,
  output logic tx_q_o,
  output logic rx_q_o,
  output logic tx_fall_o
);
  logic tx_q, rx_q, tx_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
      tx_p <= 1'b0;
    end else begin
      tx_q <= tx_act_i;
      rx_q <= rx_act_i;
      tx_p <= tx_q;
    end
  end

  assign tx_q_o    = tx_q;
  assign rx_q_o    = rx_q;
  assign tx_fall_o = tx_p & ~tx_q;
endmodule

// File: rtl/col_hb_timer.sv
module col_hb_timer #(
  parameter int PULSE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic kill_i,
  output logic run_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (kill_i)        cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign run_o = (cnt_q != '0);
endmodule

// File: rtl/col_hb_gen.sv
module col_hb_gen
  import col_hb_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int PULSE_CYC  = CLK_PER_US
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic speed100_i,
  input  logic full_dup_i,
  input  logic hb_en_i,
  input  logic rmii_i,
  output logic col_o
);
  col_mode_e mode;
  logic      tx_q, rx_q, tx_fall, hb_run, hb_ok, col_d, col_q;

  col_hb_mode u_mode (
    .speed100_i (speed100_i),
    .full_dup_i (full_dup_i),
    .hb_en_i    (hb_en_i),
    .rmii_i     (rmii_i),
    .mode_o     (mode)
  );

  col_hb_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_act_i  (tx_act_i),
    .rx_act_i  (rx_act_i),
    .tx_q_o    (tx_q),
    .rx_q_o    (rx_q),
    .tx_fall_o (tx_fall)
  );

  assign hb_ok = (mode == MODE_COL_HB);

  col_hb_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_fall & hb_ok),
    .kill_i  (tx_q),
    .run_o   (hb_run)
  );

  // a fresh transmission masks a running pulse in the same cycle
  always_comb begin
    col_d = 1'b0;
    if (mode != MODE_OFF)
      col_d = (tx_q & rx_q) | (hb_run & ~tx_q & hb_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= 1'b0;
    else         col_q <= col_d;
  end

  assign col_o = col_q;
endmodule

// File: rtl/col_hb_chk.sv
module col_hb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_act_i,
  input logic rx_act_i,
  input logic speed100_i,
  input logic full_dup_i,
  input logic hb_en_i,
  input logic rmii_i,
  input logic col_o
);
  AST_OVERLAP_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i && rx_act_i && !full_dup_i && !rmii_i) ##1 (!full_dup_i && !rmii_i) |=> col_o); // R1

  AST_FDX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_dup_i |=> !col_o); // R2

  AST_RMII_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmii_i |=> !col_o); // R5

  AST_FAST_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed100_i && !($past(tx_act_i) && $past(rx_act_i))) |=> !col_o); // R6

  AST_HB_OFF_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hb_en_i && !($past(tx_act_i) && $past(rx_act_i))) |=> !col_o); // R7

  AST_TX_MASKS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i && !rx_act_i) |=> ##1 !col_o); // R8

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_LOW: assert (!col_o); // R9
endmodule

bind col_hb_gen col_hb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_act_i   (tx_act_i),
  .rx_act_i   (rx_act_i),
  .speed100_i (speed100_i),
  .full_dup_i (full_dup_i),
  .hb_en_i    (hb_en_i),
  .rmii_i     (rmii_i),
  .col_o      (col_o)
);

// File: tb/sim_col_hb_gen.sv
module sim_col_hb_gen;
  localparam int CPU = 100;
  localparam int P   = CPU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx = 1'b0, rx = 1'b0, spd = 1'b0, fdx = 1'b0, hbe = 1'b1, rmii = 1'b0;
  logic col;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  string tag = "R9";

  always #5 clk = ~clk;

  col_hb_gen #(.CLK_PER_US(CPU)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_act_i(tx), .rx_act_i(rx),
    .speed100_i(spd), .full_dup_i(fdx), .hb_en_i(hb_en_wire()), .rmii_i(rmii),
    .col_o(col)
  );

  function automatic logic hb_en_wire();
    return hbe;
  endfunction

  // behavioural reference: sampled input history plus remaining pulse cycles
  bit s1, s2, r1, m_col;
  int hb_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; r1 = 0; hb_left = 0; m_col = 0;
    end else begin
      bit link_ok, pulse_ok;
      link_ok  = !rmii && !fdx;
      pulse_ok = link_ok && !spd && hbe;
      m_col = link_ok && ((s1 && r1) || (hb_left > 0 && !s1 && pulse_ok));
      if (s1) hb_left = 0;
      else if (s2 && !s1 && pulse_ok) hb_left = P;
      else if (hb_left > 0) hb_left = hb_left - 1;
      s2 = s1; s1 = tx; r1 = rx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (col !== m_col) begin
        n_fail++;
        $display("FAIL %s cycle compare: col_o=%0b expected=%0b at %0t", tag, col, m_col, $time);
      end
    end
  end

  task automatic chk(input string t, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic end_tx_count(output int highs);
    highs = 0;
    @(negedge clk); tx = 1'b1; rx = 1'b0;
    cyc(6);
    tx = 1'b0;
    for (int i = 0; i < P + 12; i++) begin
      @(negedge clk);
      if (col) highs++;
    end
  endtask

  initial begin
    int h;
    // R9: reset holds output low with both activities high
    tx = 1'b1; rx = 1'b1;
    cyc(4);
    chk("R9 reset", col, 0);
    tx = 1'b0; rx = 1'b0;
    rst_n = 1'b1;
    cyc(3);
    chk("R9 idle after reset", col, 0);

    // R1: overlap at 10 Mb/s, heartbeat disabled
    tag = "R1"; hbe = 1'b0; spd = 1'b0;
    tx = 1'b1; rx = 1'b1;
    @(negedge clk); chk("R1 10M edge1", col, 0);
    @(negedge clk); chk("R1 10M edge2", col, 1);
    cyc(3);
    tx = 1'b0; rx = 1'b0;
    @(negedge clk); chk("R1 hold one edge", col, 1);
    @(negedge clk); chk("R1 drop", col, 0);
    // R1 at 100 Mb/s, only rx first then tx
    spd = 1'b1; hbe = 1'b1;
    rx = 1'b1; cyc(3); tx = 1'b1;
    cyc(2); chk("R1 100M overlap", col, 1);
    tx = 1'b0; cyc(5); rx = 1'b0;
    chk("R6 no pulse at 100M", col, 0);

    // R3: pulse width at 10 Mb/s half-duplex
    tag = "R3"; spd = 1'b0; hbe = 1'b1;
    cyc(3);
    end_tx_count(h);
    chk("R3 pulse width", h, P);

    // R8: new transmission cuts a running pulse
    tag = "R8";
    tx = 1'b1; cyc(4); tx = 1'b0;
    cyc(20);
    chk("R8 pulse running", col, 1);
    tx = 1'b1;
    @(negedge clk); chk("R8 first edge still high", col, 1);
    @(negedge clk); chk("R8 cut", col, 0);
    cyc(5);
    // R8/R1: rx joins during pulse, then tx restarts on top of it
    tx = 1'b0; cyc(30);
    rx = 1'b1; cyc(10);
    chk("R3 pulse with rx", col, 1);
    tx = 1'b1; cyc(2);
    chk("R1 handover to overlap", col, 1);
    tx = 1'b0; rx = 1'b0;
    cyc(1); chk("R1 overlap tail", col, 1);
    cyc(1); chk("R8 no stale pulse", col, 0);
    cyc(P + 5);

    // R2/R4: full duplex
    tag = "R4"; fdx = 1'b1;
    tx = 1'b1; rx = 1'b1; cyc(4);
    chk("R2 fdx overlap", col, 0);
    rx = 1'b0; cyc(2);
    end_tx_count(h);
    chk("R4 no pulse in fdx", h, 0);
    fdx = 1'b0; cyc(2);

    // R5: RMII
    tag = "R5"; rmii = 1'b1;
    tx = 1'b1; rx = 1'b1; cyc(4);
    chk("R5 rmii overlap", col, 0);
    rx = 1'b0;
    end_tx_count(h);
    chk("R5 rmii no pulse", h, 0);
    rmii = 1'b0; cyc(2);

    // R6: 100 Mb/s with enable set
    tag = "R6"; spd = 1'b1; hbe = 1'b1;
    end_tx_count(h);
    chk("R6 pulse at 100M", h, 0);

    // R7: heartbeat disabled at 10 Mb/s
    tag = "R7"; spd = 1'b0; hbe = 1'b0;
    end_tx_count(h);
    chk("R7 pulse disabled", h, 0);

    // mode change mid-pulse compared by the model
    tag = "R2"; hbe = 1'b1;
    tx = 1'b1; cyc(3); tx = 1'b0; cyc(10);
    fdx = 1'b1; @(negedge clk); chk("R2 fdx mid pulse", col, 0);
    fdx = 1'b0; cyc(P);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule